// File: doc/BRIEF.md
# Multi-lane serial bit shifter

This block sits between a byte-wide datapath and the two or four bidirectional data lanes of a multi-I/O serial memory bus. In the dual-lane input phase it gathers an address and a byte of mode bits that arrive two bits per clock. In the dual-lane and quad-lane output phases it takes bytes from a ready/valid source and spreads each one across the lanes, two or four bits per clock. The bits are interleaved across the lanes one by one: neighbouring bits of a byte leave on neighbouring lanes in the same clock.

A controller around the block selects the phase with `lane_mode` and frames each transfer with the active-low select `csel_n`. Output keeps going byte after byte for as long as the source supplies data and the select stays low. Raising the select ends the phase, releases the lanes and discards any byte that was only partly sent.

Top module: `multi_lane_shifter`

## Requirements
- R1: In dual output (`lane_mode` = 2'b01) a byte is sent in four slots k = 0..3. In slot k lane 1 carries bit 7-2k and lane 0 carries bit 6-2k. Lanes 2 and 3 are driven 0 with enable 0.
- R2: In quad output (`lane_mode` = 2'b10) a byte is sent in two slots k = 0..1. In slot k lane j (j = 0..3) carries bit 4-4k+j.
- R3: `tx_ready` is high while no byte is loaded and during the last slot of the current byte. A byte accepted on an edge drives its slot 0 in the next cycle, so a byte offered in the last slot follows with no gap.
- R4: `tx_ready` is low whenever `csel_n` is high or `lane_mode` is not an output mode.
- R5: While `csel_n` is high all lane enables are 0. A partly sent byte is dropped, and the next phase starts again at slot 0 of a newly accepted byte.
- R6: In dual input (`lane_mode` = 2'b00) the lane enables stay 0 and the block samples `lane_in` on 16 edges. In each pair lane 1 holds the more significant bit. The first 24 bits received, MSB first, form `addr_out` and the last 8 form `mbits_out`.
- R7: `addr_done` is high for exactly the one cycle after the 16th sampling edge. `addr_out` and `mbits_out` then hold, and further lane activity is ignored until `csel_n` rises.
- R8: If no byte is valid during the last slot, the lanes keep their last value and `tx_ready` stays high.
- R9: Once a byte is loaded, `lane_oe` is 4'b0011 in dual output and 4'b1111 in quad output. It is 4'b0000 before the first byte of a phase is accepted.
- R10: `lane_mode` = 2'b11 is idle: no lane is enabled, `tx_ready` is low and nothing is captured.
- R11: An asynchronous low on `rst_n` clears the lane enables, the lane values, `addr_out`, `mbits_out` and `addr_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csel_n | input | 1 | Active-low transfer select |
| lane_mode | input | 2 | 00 dual in, 01 dual out, 10 quad out, 11 idle |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Block accepts `tx_data` on this edge |
| lane_in | input | 2 | Sampled values of lanes 1 and 0 |
| lane_out | output | 4 | Lane drive values |
| lane_oe | output | 4 | Per-lane output enables |
| addr_out | output | 24 | Captured address |
| mbits_out | output | 8 | Captured mode bits |
| addr_done | output | 1 | One-cycle pulse when a capture completes |

## Verification
The bench builds the block with its default widths: an 8-bit byte, a 24-bit address and 8 mode bits. These give a 16-clock input field, four slots per byte in dual output and two in quad output, so every slot counter wraps and every boundary of the input field is reached within a short run. Each output byte is put back together from the lane samples by shifting and compared with the byte that was sent. Each captured field is compared with the word that was driven onto the lanes.

// File: rtl/mls_pkg.sv
package mls_pkg;

  localparam int NLANES = 4;

  typedef enum logic [1:0] {
    LM_DIN  = 2'b00,
    LM_DOUT = 2'b01,
    LM_QOUT = 2'b10,
    LM_IDLE = 2'b11
  } lane_mode_e;

  // Bit of the byte that lane `lane` carries in slot `slot` when `lanes`
  // lanes are active: slots run from the top of the byte downward.
  function automatic int lane_bit_index(input int lanes, input int slot,
                                        input int lane, input int bw);
    return bw - lanes * (slot + 1) + lane;
  endfunction

  // Number of slots needed to move one byte over `lanes` lanes.
  function automatic int slots_per_byte(input int lanes, input int bw);
    return bw / lanes;
  endfunction

endpackage

// File: rtl/mls_mode_decode.sv
module mls_mode_decode (
  input  logic       csel_n,
  input  logic [1:0] lane_mode,
  output logic       out_en,
  output logic       quad_sel,
  output logic       in_en
);
  import mls_pkg::*;

  lane_mode_e md;
  assign md = lane_mode_e'(lane_mode);

  always_comb begin
    out_en   = 1'b0;
    quad_sel = 1'b0;
    in_en    = 1'b0;
    if (!csel_n) begin
      unique case (md)
        LM_DIN:  in_en = 1'b1;
        LM_DOUT: out_en = 1'b1;
        LM_QOUT: begin out_en = 1'b1; quad_sel = 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mls_tx_serializer.sv
module mls_tx_serializer #(
  parameter int BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       en,
  input  logic                       quad,
  input  logic [BYTE_W-1:0]          tx_data,
  input  logic                       tx_valid,
  output logic                       tx_ready,
  output logic [mls_pkg::NLANES-1:0] lane_out,
  output logic [mls_pkg::NLANES-1:0] lane_oe,
  output logic                       slot_last,
  output logic                       take
);
  import mls_pkg::*;

  localparam int DSLOTS = slots_per_byte(2, BYTE_W);
  localparam int QSLOTS = slots_per_byte(NLANES, BYTE_W);
  localparam int SW     = (DSLOTS > 1) ? $clog2(DSLOTS) : 1;
  localparam int IW     = $clog2(BYTE_W);

  logic [BYTE_W-1:0] byte_q;
  logic [SW-1:0]     slot_q;
  logic              loaded_q;

  assign slot_last = quad ? (slot_q == SW'(QSLOTS - 1))
                          : (slot_q == SW'(DSLOTS - 1));
  assign tx_ready  = en && (!loaded_q || slot_last);
  assign take      = tx_ready && tx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q   <= '0;
      slot_q   <= '0;
      loaded_q <= 1'b0;
    end else if (clear) begin
      slot_q   <= '0;
      loaded_q <= 1'b0;
    end else if (take) begin
      byte_q   <= tx_data;
      slot_q   <= '0;
      loaded_q <= 1'b1;
    end else if (en && loaded_q && !slot_last) begin
      slot_q   <= slot_q + SW'(1);
    end
  end

  for (genvar j = 0; j < NLANES; j++) begin : g_lane
    logic [IW-1:0] qsel;
    logic          qbit;
    logic          dbit;
    assign qsel = IW'(lane_bit_index(NLANES, int'(slot_q), j, BYTE_W));
    assign qbit = byte_q[qsel];
    if (j < 2) begin : g_dual
      logic [IW-1:0] dsel;
      assign dsel = IW'(lane_bit_index(2, int'(slot_q), j, BYTE_W));
      assign dbit = byte_q[dsel];
    end else begin : g_quad_only
      assign dbit = 1'b0;
    end
    assign lane_out[j] = loaded_q ? (quad ? qbit : dbit) : 1'b0;
    assign lane_oe[j]  = en && loaded_q && (quad || (j < 2));
  end
endmodule

// File: rtl/mls_rx_deserializer.sv
module mls_rx_deserializer #(
  parameter int ADDR_W = 24,
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              en,
  input  logic [1:0]        lane_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [MODE_W-1:0] mbits_out,
  output logic              done,
  output logic              sampling
);
  localparam int FIELD = ADDR_W + MODE_W;
  localparam int CYC   = FIELD / 2;
  localparam int CW    = $clog2(CYC);

  logic [FIELD-1:0] acc_q;
  logic [FIELD-1:0] acc_nx;
  logic [CW-1:0]    cnt_q;
  logic             finished_q;

  assign sampling = en && !finished_q;
  assign acc_nx   = {acc_q[FIELD-3:0], lane_in[1], lane_in[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= '0;
      cnt_q      <= '0;
      finished_q <= 1'b0;
      addr_out   <= '0;
      mbits_out  <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clear) begin
        cnt_q      <= '0;
        finished_q <= 1'b0;
      end else if (sampling) begin
        acc_q <= acc_nx;
        if (cnt_q == CW'(CYC - 1)) begin
          cnt_q                 <= '0;
          finished_q            <= 1'b1;
          {addr_out, mbits_out} <= acc_nx;
          done                  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/multi_lane_shifter.sv
module multi_lane_shifter #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 24,
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csel_n,
  input  logic [1:0]        lane_mode,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [1:0]        lane_in,
  output logic [3:0]        lane_out,
  output logic [3:0]        lane_oe,
  output logic [ADDR_W-1:0] addr_out,
  output logic [MODE_W-1:0] mbits_out,
  output logic              addr_done
);
  logic out_en;
  logic quad_sel;
  logic in_en;
  logic ser_last;
  logic ser_take;
  logic des_sampling;

  mls_mode_decode u_dec (
    .csel_n    (csel_n),
    .lane_mode (lane_mode),
    .out_en    (out_en),
    .quad_sel  (quad_sel),
    .in_en     (in_en)
  );

  mls_tx_serializer #(.BYTE_W(BYTE_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (csel_n),
    .en        (out_en),
    .quad      (quad_sel),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .lane_out  (lane_out),
    .lane_oe   (lane_oe),
    .slot_last (ser_last),
    .take      (ser_take)
  );

  mls_rx_deserializer #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (csel_n),
    .en        (in_en),
    .lane_in   (lane_in),
    .addr_out  (addr_out),
    .mbits_out (mbits_out),
    .done      (addr_done),
    .sampling  (des_sampling)
  );
endmodule

// File: rtl/mls_shifter_chk.sv
module mls_shifter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       csel_n,
  input logic [1:0] lane_mode,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [3:0] lane_out,
  input logic [3:0] lane_oe,
  input logic       addr_done,
  input logic       ser_last,
  input logic       ser_take,
  input logic       des_sampling
);
  assert_oe_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    csel_n |-> (lane_oe == 4'b0000));

  assert_oe_off_in_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode == 2'b00) |-> (lane_oe == 4'b0000));

  assert_dual_upper_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode == 2'b01) |-> (lane_oe[3:2] == 2'b00));

  assert_ready_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!csel_n && (lane_mode == 2'b01 || lane_mode == 2'b10)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode == 2'b11) |-> (!tx_ready && lane_oe == 4'b0000 && !des_sampling));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done |=> !addr_done);

  assert_hold_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_last && tx_ready && !tx_valid && !csel_n)
      |=> (csel_n || lane_mode != $past(lane_mode) || $stable(lane_out)));

  assert_take_handshake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ser_take |-> (tx_ready && tx_valid));
endmodule

bind multi_lane_shifter mls_shifter_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .csel_n       (csel_n),
  .lane_mode    (lane_mode),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .lane_out     (lane_out),
  .lane_oe      (lane_oe),
  .addr_done    (addr_done),
  .ser_last     (ser_last),
  .ser_take     (ser_take),
  .des_sampling (des_sampling)
);

// File: tb/multi_lane_shifter_test.sv
module multi_lane_shifter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csel_n = 1'b1;
  logic [1:0]  lane_mode = 2'b11;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [1:0]  lane_in = '0;
  logic [3:0]  lane_out;
  logic [3:0]  lane_oe;
  logic [23:0] addr_out;
  logic [7:0]  mbits_out;
  logic        addr_done;

  int checks = 0;
  int errors = 0;

  multi_lane_shifter uut (
    .clk(clk), .rst_n(rst_n), .csel_n(csel_n), .lane_mode(lane_mode),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .lane_in(lane_in), .lane_out(lane_out), .lane_oe(lane_oe),
    .addr_out(addr_out), .mbits_out(mbits_out), .addr_done(addr_done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected enable pattern for a loaded output phase.
  function automatic logic [3:0] exp_oe(input logic [1:0] md);
    return (md == 2'b10) ? 4'b1111 : 4'b0011;
  endfunction

  // Send n bytes and rebuild each one from the lane samples by shifting.
  task automatic out_stream(input logic [1:0] md, input logic [7:0] b [8], input int n);
    int L = (md == 2'b10) ? 4 : 2;
    int S = 8 / L;
    string rq = (md == 2'b10) ? "R2" : "R1";
    logic [3:0] last;
    @(negedge clk);
    csel_n = 1'b0; lane_mode = md; tx_valid = 1'b1; tx_data = b[0];
    #1;
    chk("R3", "ready with no byte loaded", 32'(tx_ready), 1);
    chk("R9", "oe before first byte", 32'(lane_oe), 0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] r = '0;
      for (int k = 0; k < S; k++) begin
        @(negedge clk);
        r = (L == 4) ? {r[3:0], lane_out} : {r[5:0], lane_out[1:0]};
        if (L == 2) chk("R1", "lanes 2,3 quiet in dual", 32'(lane_out[3:2]), 0);
        if (k == 0) begin
          chk("R9", "oe pattern", 32'(lane_oe), 32'(exp_oe(md)));
          chk("R3", "ready low in first slot", 32'(tx_ready), 0);
        end
        if (k == S - 1) begin
          chk("R3", "ready in last slot", 32'(tx_ready), 1);
          if (i < n - 1) tx_data = b[i + 1];
          else tx_valid = 1'b0;
        end
      end
      chk(rq, "reassembled byte", 32'(r), 32'(b[i]));
    end
    last = lane_out;
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      chk("R8", "lanes hold without data", 32'(lane_out), 32'(last));
      chk("R8", "ready stays high", 32'(tx_ready), 1);
    end
    csel_n = 1'b1;
    #1;
    chk("R5", "oe released", 32'(lane_oe), 0);
    chk("R4", "ready low when deselected", 32'(tx_ready), 0);
    @(negedge clk);
  endtask

  task automatic in_field(input logic [31:0] w);
    @(negedge clk);
    csel_n = 1'b0; lane_mode = 2'b00; tx_valid = 1'b1;
    for (int c = 0; c < 16; c++) begin
      lane_in = {w[31 - 2 * c], w[30 - 2 * c]};
      if (c == 0) begin
        #1;
        chk("R4", "ready low in input phase", 32'(tx_ready), 0);
        chk("R6", "oe off in input phase", 32'(lane_oe), 0);
      end
      @(negedge clk);
      if (c < 15) chk("R7", "no early done", 32'(addr_done), 0);
    end
    chk("R7", "done pulse", 32'(addr_done), 1);
    chk("R6", "address", 32'(addr_out), 32'(w[31:8]));
    chk("R6", "mode bits", 32'(mbits_out), 32'(w[7:0]));
    for (int g = 0; g < 20; g++) begin
      lane_in = 2'($urandom);
      @(negedge clk);
      chk("R7", "done single cycle", 32'(addr_done), 0);
    end
    chk("R7", "address held", 32'(addr_out), 32'(w[31:8]));
    chk("R7", "mode bits held", 32'(mbits_out), 32'(w[7:0]));
    csel_n = 1'b1; tx_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] bb [8];
    void'($urandom(32'd4711));
    #2;
    chk("R11", "oe in reset", 32'(lane_oe), 0);
    chk("R11", "done in reset", 32'(addr_done), 0);
    chk("R11", "addr in reset", 32'(addr_out), 0);
    chk("R11", "lanes in reset", 32'(lane_out), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int t = 0; t < 4; t++) begin
      for (int i = 0; i < 8; i++) bb[i] = 8'($urandom);
      out_stream(2'b01, bb, 6);
      for (int i = 0; i < 8; i++) bb[i] = 8'($urandom);
      out_stream(2'b10, bb, 6);
    end
    bb = '{8'hA5, 8'h00, 8'hFF, 8'h5A, 8'h80, 8'h01, 8'h7E, 8'h81};
    out_stream(2'b01, bb, 8);
    out_stream(2'b10, bb, 8);
    out_stream(2'b10, bb, 1);

    // R5: abort part way through a byte, then restart cleanly
    @(negedge clk);
    csel_n = 1'b0; lane_mode = 2'b01; tx_valid = 1'b1; tx_data = 8'h3C;
    @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    csel_n = 1'b1;
    #1;
    chk("R5", "oe off after abort", 32'(lane_oe), 0);
    @(negedge clk);
    bb = '{8'hC3, 8'h96, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    out_stream(2'b01, bb, 2);

    for (int t = 0; t < 5; t++) in_field($urandom);
    in_field(32'hFFFFFF00);
    in_field(32'h000000FF);
    in_field(32'hAAAAAA55);

    // R10: idle code
    @(negedge clk);
    csel_n = 1'b0; lane_mode = 2'b11; tx_valid = 1'b1;
    for (int g = 0; g < 20; g++) begin
      lane_in = 2'($urandom);
      @(negedge clk);
      chk("R10", "idle ready", 32'(tx_ready), 0);
      chk("R10", "idle oe", 32'(lane_oe), 0);
      chk("R10", "idle done", 32'(addr_done), 0);
    end
    csel_n = 1'b1; tx_valid = 1'b0;

    // R11: reset in the middle of an output byte
    @(negedge clk);
    csel_n = 1'b0; lane_mode = 2'b10; tx_valid = 1'b1; tx_data = 8'hFF;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11", "oe after async reset", 32'(lane_oe), 0);
    chk("R11", "lanes after async reset", 32'(lane_out), 0);
    chk("R11", "addr after async reset", 32'(addr_out), 0);
    chk("R11", "mode bits after async reset", 32'(mbits_out), 0);
    tx_valid = 1'b0; csel_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule